// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side on the fetch address. The first is a table of 2-bit saturating counters indexed by the branch address alone. The second is a table of the same counters indexed by an 8-bit record of recent resolved outcomes, XORed with address bits. A third table of 2-bit counters, also indexed by address, decides for each branch which component's guess goes out. The prediction is combinational from the fetch address. The block returns both component guesses so the pipeline can carry them to resolution.

When a branch resolves, the pipeline presents its address, its real direction and the two component guesses that were made for it. At the next clock edge the following happens:

- Both component counters move toward the real direction.
- The selector moves toward whichever component was right, but only if exactly one of them was right.
- The outcome is shifted into the history.

The history changes only at resolution. Unconditional jumps are handled elsewhere and never reach this block. Predicting branch targets is also outside its job.

Top module: `tourney_bp`

## Requirements
- R1: After reset every component counter and selector entry holds 1 and the history holds 0, so every address predicts not-taken with both component outputs at 0.
- R2: The address-only counter is selected by address bits [9:2]. Bits [1:0] and bits above 9 are ignored, so addresses equal in bits [9:2] share one counter. Each update moves that counter one step toward the real direction.
- R3: The history-based counter is selected by the history XOR address bits [9:2]. The history used is the one held when the address is presented. Each update moves that counter one step toward the real direction.
- R4: A counter value of 2 or 3 means taken, and 0 or 1 means not-taken. This applies to both components and to their outputs `pred_bim` and `pred_gsh`.
- R5: The selector entry at address bits [9:2] picks the output. A value of 2 or 3 sends out the history-based guess, and 0 or 1 sends out the address-only guess. When both guesses agree, that value is the output.
- R6: On an update, the selector entry steps up (toward the history-based side) when only `upd_gsh` equals the outcome. It steps down when only `upd_bim` equals it. It stays unchanged when both guesses, or neither, were right.
- R7: Each update shifts the history left by one and places the outcome in bit 0. The history is 8 bits wide.
- R8: The prediction depends only on the current address and the stored state. An update is visible only after the next rising edge. While `upd_valid` is 0, the values on `upd_pc`, `upd_taken`, `upd_bim` and `upd_gsh` change nothing.
- R9: Counters saturate. A counter at 3 stays at 3 on a taken update, and a counter at 0 stays at 0 on a not-taken update. A counter at 3 therefore still predicts taken after one not-taken update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction guess for `pred_pc` |
| pred_bim | output | 1 | Address-only component guess |
| pred_gsh | output | 1 | History-based component guess |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | 32 | Address of the resolving branch |
| upd_taken | input | 1 | Real direction of the resolving branch |
| upd_bim | input | 1 | Address-only guess made for it |
| upd_gsh | input | 1 | History-based guess made for it |

## Verification
The block is driven with several branch patterns, each aimed at a different part of the logic:

- An always-taken branch shows the address-only counter learning and saturating.
- A strictly alternating branch can only be learned through history. It shows the selector drifting to the history side.
- An always-not-taken branch, on which both components agree, shows that the selector stays put.
- Addresses that differ only outside bits [9:2] confirm that the table entries are shared.
- Idle cycles with noisy update fields confirm that nothing changes without `upd_valid`.
- A long random mix, including component guesses that disagree with the stored tables, compares all three outputs with a behavioural model on every cycle.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LO = 2'd1;
  localparam ctr2_t CTR_MAX     = 2'd3;
  localparam ctr2_t CTR_MIN     = 2'd0;

  // One saturating step toward taken (up=1) or not-taken (up=0).
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else    r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_high(input ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/tbp_rst_sync.sv
module tbp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int    IDX_W   = 8,
  parameter ctr2_t RST_VAL = 2'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int FLAT_W = 2 * DEPTH;

  logic [FLAT_W-1:0] flat;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic  hit;
    ctr2_t cur_q;
    ctr2_t nxt;

    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_comb begin
      nxt = cur_q;
      if (hit) nxt = ctr_step(cur_q, wr_up);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cur_q <= RST_VAL;
      else if (hit) cur_q <= nxt;
    end

    assign flat[2*e +: 2] = cur_q;
  end

  assign rd_ctr = flat[2*rd_idx +: 2];

endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int BIM_IDX_W = 8,
  parameter int HIST_W    = 8,
  parameter int SEL_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_bim,
  output logic            pred_gsh,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_bim,
  input  logic            upd_gsh
);

  localparam int GSH_IDX_W = HIST_W;

  logic              rst_q;
  logic [HIST_W-1:0] hist_q;

  logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
  logic [GSH_IDX_W-1:0] gsh_rd_idx, gsh_wr_idx;
  logic [SEL_IDX_W-1:0] sel_rd_idx, sel_wr_idx;
  ctr2_t                bim_ctr, gsh_ctr, sel_ctr;
  logic                 sel_wr_en, sel_wr_up;

  tbp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  tbp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_q),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_o   (hist_q)
  );

  // Index formation: address bits above the byte offset; history-based
  // table folds the outcome record onto the same address bits.
  always_comb begin
    bim_rd_idx = pred_pc[PC_LSB +: BIM_IDX_W];
    bim_wr_idx = upd_pc[PC_LSB +: BIM_IDX_W];
    sel_rd_idx = pred_pc[PC_LSB +: SEL_IDX_W];
    sel_wr_idx = upd_pc[PC_LSB +: SEL_IDX_W];
    gsh_rd_idx = hist_q ^ pred_pc[PC_LSB +: GSH_IDX_W];
    gsh_wr_idx = hist_q ^ upd_pc[PC_LSB +: GSH_IDX_W];
  end

  // Selector training: only when the two components disagreed,
  // i.e. exactly one of them matched the outcome.
  always_comb begin
    sel_wr_en = upd_valid && (upd_bim != upd_gsh);
    sel_wr_up = (upd_gsh == upd_taken);
  end

  tbp_ctr_table #(.IDX_W(BIM_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_bim (
    .clk    (clk),
    .rst_n  (rst_q),
    .rd_idx (bim_rd_idx),
    .rd_ctr (bim_ctr),
    .wr_en  (upd_valid),
    .wr_idx (bim_wr_idx),
    .wr_up  (upd_taken)
  );

  tbp_ctr_table #(.IDX_W(GSH_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_gsh (
    .clk    (clk),
    .rst_n  (rst_q),
    .rd_idx (gsh_rd_idx),
    .rd_ctr (gsh_ctr),
    .wr_en  (upd_valid),
    .wr_idx (gsh_wr_idx),
    .wr_up  (upd_taken)
  );

  tbp_ctr_table #(.IDX_W(SEL_IDX_W), .RST_VAL(CTR_WEAK_LO)) u_sel (
    .clk    (clk),
    .rst_n  (rst_q),
    .rd_idx (sel_rd_idx),
    .rd_ctr (sel_ctr),
    .wr_en  (sel_wr_en),
    .wr_idx (sel_wr_idx),
    .wr_up  (sel_wr_up)
  );

  always_comb begin
    pred_bim   = ctr_high(bim_ctr);
    pred_gsh   = ctr_high(gsh_ctr);
    pred_taken = ctr_high(sel_ctr) ? pred_gsh : pred_bim;
  end

endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic              pred_bim,
  input logic              pred_gsh,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist
);

  // R7: history shifts left with the outcome in bit 0
  p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hist[0] == $past(upd_taken)) &&
                  (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

  // R8: no update, no history change
  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));

  // R5: agreeing components leave the selector no choice
  p_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_bim == pred_gsh) |-> (pred_taken == pred_bim));

  // R8: same address, no update in between, same guess
  p_pred_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(pred_pc) -> ($stable(pred_taken) &&
                    $stable(pred_bim) && $stable(pred_gsh))));

endmodule

bind tourney_bp tourney_bp_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .pred_bim   (pred_bim),
  .pred_gsh   (pred_gsh),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .hist       (hist_q)
);

// File: tb/tourney_bp_test.sv
`timescale 1ns/1ps
module tourney_bp_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc;
  logic        pred_taken, pred_bim, pred_gsh;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken, upd_bim, upd_gsh;

  always #4 clk = ~clk; // 125 MHz

  tourney_bp uut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_bim(pred_bim), .pred_gsh(pred_gsh),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_bim(upd_bim), .upd_gsh(upd_gsh)
  );

  // Behavioural reference state
  int m_bim[256];
  int m_gsh[256];
  int m_sel[256];
  int m_hist;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hFF);
  endfunction

  function automatic int sat(input int v);
    return (v > 3) ? 3 : ((v < 0) ? 0 : v);
  endfunction

  function automatic bit exp_bim(input logic [31:0] pc);
    return m_bim[idx_of(pc)] >= 2;
  endfunction

  function automatic bit exp_gsh(input logic [31:0] pc);
    return m_gsh[(m_hist ^ idx_of(pc)) & 255] >= 2;
  endfunction

  function automatic bit exp_final(input logic [31:0] pc);
    return (m_sel[idx_of(pc)] >= 2) ? exp_gsh(pc) : exp_bim(pc);
  endfunction

  task automatic model_update(input logic [31:0] pc, input bit t,
                              input bit b, input bit g);
    int i, gi;
    i  = idx_of(pc);
    gi = (m_hist ^ i) & 255;
    m_bim[i]  = sat(m_bim[i] + (t ? 1 : -1));
    m_gsh[gi] = sat(m_gsh[gi] + (t ? 1 : -1));
    if (b != g) m_sel[i] = sat(m_sel[i] + ((g == t) ? 1 : -1));
    m_hist = ((m_hist << 1) | int'(t)) & 255;
  endtask

  task automatic step(input logic [31:0] ppc, input bit uv,
                      input logic [31:0] upc, input bit ut,
                      input bit ub, input bit ug, input string tag);
    bit et, eb, eg;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc;
    upd_taken = ut; upd_bim = ub; upd_gsh = ug;
    #1;
    et = exp_final(ppc); eb = exp_bim(ppc); eg = exp_gsh(ppc);
    n_chk++;
    if (pred_taken !== et || pred_bim !== eb || pred_gsh !== eg) begin
      n_bad++;
      $display("FAIL %s pc=%h taken/bim/gsh actual=%b%b%b expected=%b%b%b",
               tag, ppc, pred_taken, pred_bim, pred_gsh, et, eb, eg);
    end
    if (uv) model_update(upc, ut, ub, ug);
  endtask

  // Resolve a branch with the component guesses the model made for it.
  task automatic resolve(input logic [31:0] ppc, input logic [31:0] upc,
                         input bit t, input string tag);
    step(ppc, 1'b1, upc, t, exp_bim(upc), exp_gsh(upc), tag);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          n_bad++;
          $display("FAIL watchdog expired");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_bim[i] = 1; m_gsh[i] = 1; m_sel[i] = 1;
    end
    m_hist = 0;
    rst_n = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_bim = 1'b0; upd_gsh = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state predicts not-taken everywhere
    for (int i = 0; i < 8; i++)
      step(32'h40 * i + 32'h1000, 0, '0, 0, 0, 0, "R1");

    // R4 and R2: always-taken branch trains its address-only counter
    resolve(32'h100, 32'h100, 1, "R2");
    step(32'h100, 0, '0, 0, 0, 0, "R4");
    // R2: alias in bits [9:2], differing low and high bits
    step(32'h503, 0, '0, 0, 0, 0, "R2");
    // R9: saturate, then one not-taken keeps it taken
    for (int i = 0; i < 4; i++) resolve(32'h100, 32'h100, 1, "R9");
    resolve(32'h100, 32'h100, 0, "R9");
    step(32'h100, 0, '0, 0, 0, 0, "R9");
    // R9: saturate at the low end
    for (int i = 0; i < 5; i++) resolve(32'h200, 32'h200, 0, "R9");
    step(32'h200, 0, '0, 0, 0, 0, "R9");

    // R3 and R6: alternating branch, only history can learn it
    for (int i = 0; i < 40; i++) begin
      step(32'h300, 0, '0, 0, 0, 0, "R3");
      resolve(32'h300, 32'h300, i[0], "R6");
    end

    // R6: both components agree, selector stays put
    for (int i = 0; i < 12; i++) resolve(32'h340, 32'h340, 0, "R6");
    step(32'h340, 0, '0, 0, 0, 0, "R6");

    // R8: idle cycles with noisy update fields change nothing
    for (int i = 0; i < 20; i++)
      step(32'h300, 0, $urandom, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1), "R8");

    // R7: history-sensitive stream with a recurring pattern
    for (int i = 0; i < 200; i++)
      resolve(32'h380, 32'h380 + ((i % 3) << 2), (i % 3) != 0, "R7");

    // R5: random mix, arbitrary component guesses on update
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = {$urandom_range(0, 3), 6'($urandom_range(0, 15)), 2'($urandom)} ;
      b = {$urandom_range(0, 3), 6'($urandom_range(0, 15)), 2'($urandom)} ;
      if ($urandom_range(0, 3) == 0)
        step(a, 0, b, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), "R8");
      else if ($urandom_range(0, 1) == 0)
        resolve(a, b, $urandom_range(0, 4) != 0, "R5");
      else
        step(a, 1, b, $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), "R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule